// File: doc/BRIEF.md
# Interleaved NOR Flash Command Sequencer

This block sits on the host side of a parallel NOR flash bank built from several narrow devices placed side by side on one wide data bus. A client issues one request at a time over a valid/ready handshake. Each request names an operation, a word address and a data word. The block expands the request into the unlock and command writes the flash devices expect. Every command is sent to all devices at once, so their internal state machines stay in step.

Command addresses are given in the devices' own word units and are scaled to bus byte addresses. Command bytes are repeated in every device lane. After a program or an erase, the block polls the toggling status bit until it stops. A poll budget ends a stuck operation with a reset write and an error flag. Reads of identification and query data return the captured bus word.

Top module: `flash_ilv_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, `req_ready` is 1 and `rsp_done`, `bus_we` and `bus_rd` are 0.
- R2: A command write goes to bus byte address `fa * (BANK_W/DEV_W) * MAX_DEV_W`, where `fa` is the device word address. With the defaults this is `fa << 3`. Data and target accesses go to `req_addr * BANK_W`, which is `req_addr << 2` by default. A bus cycle is never a read and a write at once.
- R3: A command byte appears in every device lane, one copy every `DEV_W*8` bits. With the defaults, byte `b` is sent as `{b,b,b,b}`.
- R4: Operation code 0 (reset) makes exactly one write: 0xF0 in every lane at address 0.
- R5: Operation code 3 (program) writes 0xAA at 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555. It then writes `req_data` unchanged at the target address, and then polls.
- R6: Operation code 4 (sector erase) writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555 and 0x55@0x2AA. It then writes 0x30 in every lane at the target address, and then polls.
- R7: Operation code 5 (chip erase) makes the same five writes as R6 and then writes 0x10@0x555. Its poll reads go to bus address 0.
- R8: A poll reads the target address on consecutive cycles. It finishes when two back-to-back reads agree in every lane's bit 6 (mask 0x40 per lane).
- R9: When `POLL_LIMIT` consecutive read pairs disagree, the block writes 0xF0 in every lane at address 0. It then completes with `rsp_timeout` = 1. An operation that stays one disagreeing pair under the limit completes with `rsp_timeout` = 0.
- R10: Operation code 2 (query read) writes 0x98@0x55, then reads at the scaled address `req_addr`, then writes 0xF0@0. `rsp_data` returns the word that was read.
- R11: Operation code 1 (identification read) makes the two unlock writes and then writes 0x90@0x555. It then reads at the scaled `req_addr` and writes 0xF0@0. `rsp_data` returns the word that was read.
- R12: A request is accepted only while `req_ready` is 1, and `req_ready` falls in the next cycle. `rsp_done` is high for exactly one cycle, and `req_ready` returns in the cycle after it. A request held valid while the block is busy starts nothing.
- R13: Operation codes 6 and 7 complete with `rsp_done` and make no bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_op | input | 3 | Operation code |
| req_addr | input | REQ_AW | Target word address (bank words for data, device words for reads) |
| req_data | input | BANK_W*8 | Program data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_timeout | output | 1 | Last operation ran out of poll budget |
| rsp_data | output | BANK_W*8 | Word captured by the last read step |
| bus_addr | output | REQ_AW+CMD_SH | Flash bus byte address |
| bus_wdata | output | BANK_W*8 | Flash bus write data |
| bus_we | output | 1 | Flash write strobe, one cycle per write |
| bus_rd | output | 1 | Flash read strobe; data captured at the same edge |
| bus_rdata | input | BANK_W*8 | Flash bus read data |

## Verification
Two pairs of events can land in the same cycle. The completion pulse can coincide with a request that the client has kept valid throughout the operation. The bench holds `req_valid` high through a whole program and withdraws it only in the cycle where `rsp_done` is seen. It then confirms from the write log that no second sequence was started. The other pair is the last allowed poll comparison and budget expiry. The flash model is set to toggle exactly one pair below, and then exactly at, `POLL_LIMIT`. The outcome is judged by the timeout flag and by whether a trailing reset write shows up.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [2:0] {
      OP_RESET = 3'd0,
      OP_ID    = 3'd1,
      OP_CFI   = 3'd2,
      OP_PROG  = 3'd3,
      OP_SECT  = 3'd4,
      OP_CHIP  = 3'd5
   } op_e;

   typedef enum logic [2:0] {
      K_CMD,   // command byte at scaled device address
      K_DATA,  // raw request data at target address
      K_TGT,   // command byte at target address
      K_READ,  // read at scaled query address
      K_POLL,  // enter toggle poll
      K_END    // sequence complete
   } kind_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_STEP,
      S_POLL,
      S_TORST,
      S_DONE
   } st_e;

   typedef struct packed {
      kind_e       kind;
      logic [11:0] fa;
      logic [7:0]  cb;
   } step_t;

   localparam int          FA_W      = 12;
   localparam logic [11:0] FA_UNLK0  = 12'h555;
   localparam logic [11:0] FA_UNLK1  = 12'h2AA;
   localparam logic [11:0] FA_QRY    = 12'h055;
   localparam logic [11:0] FA_ZERO   = 12'h000;

   localparam logic [7:0]  CB_UNLK0  = 8'hAA;
   localparam logic [7:0]  CB_UNLK1  = 8'h55;
   localparam logic [7:0]  CB_PROG   = 8'hA0;
   localparam logic [7:0]  CB_ERASE  = 8'h80;
   localparam logic [7:0]  CB_SECT   = 8'h30;
   localparam logic [7:0]  CB_CHIP   = 8'h10;
   localparam logic [7:0]  CB_IDENT  = 8'h90;
   localparam logic [7:0]  CB_QUERY  = 8'h98;
   localparam logic [7:0]  CB_RST    = 8'hF0;
   localparam logic [7:0]  CB_DQ6    = 8'h40;

   function automatic step_t mk(input kind_e k, input logic [11:0] fa, input logic [7:0] cb);
      step_t s;
      s.kind = k;
      s.fa   = fa;
      s.cb   = cb;
      return s;
   endfunction

endpackage

// File: rtl/flash_step_rom.sv
module flash_step_rom
   import flash_seq_pkg::*;
(
   input  logic [2:0] op,
   input  logic [2:0] idx,
   output step_t      step
);

   step_t unlk;

   // shared two-write unlock prefix (steps 0,1 and, for erases, 3,4)
   always_comb begin
      if (idx == 3'd0 || idx == 3'd3) unlk = mk(K_CMD, FA_UNLK0, CB_UNLK0);
      else                            unlk = mk(K_CMD, FA_UNLK1, CB_UNLK1);
   end

   always_comb begin
      step = mk(K_END, FA_ZERO, 8'h00);
      case (op)
         OP_RESET: begin
            if (idx == 3'd0) step = mk(K_CMD, FA_ZERO, CB_RST);
         end
         OP_CFI: begin
            case (idx)
               3'd0:    step = mk(K_CMD, FA_QRY, CB_QUERY);
               3'd1:    step = mk(K_READ, FA_ZERO, 8'h00);
               3'd2:    step = mk(K_CMD, FA_ZERO, CB_RST);
               default: step = mk(K_END, FA_ZERO, 8'h00);
            endcase
         end
         OP_ID: begin
            case (idx)
               3'd0, 3'd1: step = unlk;
               3'd2:       step = mk(K_CMD, FA_UNLK0, CB_IDENT);
               3'd3:       step = mk(K_READ, FA_ZERO, 8'h00);
               3'd4:       step = mk(K_CMD, FA_ZERO, CB_RST);
               default:    step = mk(K_END, FA_ZERO, 8'h00);
            endcase
         end
         OP_PROG: begin
            case (idx)
               3'd0, 3'd1: step = unlk;
               3'd2:       step = mk(K_CMD, FA_UNLK0, CB_PROG);
               3'd3:       step = mk(K_DATA, FA_ZERO, 8'h00);
               3'd4:       step = mk(K_POLL, FA_ZERO, 8'h00);
               default:    step = mk(K_END, FA_ZERO, 8'h00);
            endcase
         end
         OP_SECT, OP_CHIP: begin
            case (idx)
               3'd0, 3'd1, 3'd3, 3'd4: step = unlk;
               3'd2:    step = mk(K_CMD, FA_UNLK0, CB_ERASE);
               3'd5:    step = (op == OP_SECT) ? mk(K_TGT, FA_ZERO, CB_SECT)
                                               : mk(K_CMD, FA_UNLK0, CB_CHIP);
               3'd6:    step = mk(K_POLL, FA_ZERO, 8'h00);
               default: step = mk(K_END, FA_ZERO, 8'h00);
            endcase
         end
         default: step = mk(K_END, FA_ZERO, 8'h00);
      endcase
   end

endmodule

// File: rtl/flash_lane_fan.sv
module flash_lane_fan #(
   parameter int BANK_W    = 4,
   parameter int DEV_W     = 1,
   parameter int MAX_DEV_W = 2,
   parameter int REQ_AW    = 16
) (
   input  logic [7:0]                       cmd_byte,
   input  logic [11:0]                      cmd_fa,
   input  logic [REQ_AW-1:0]                req_addr,
   output logic [BANK_W*8-1:0]              cmd_word,
   output logic [BANK_W*8-1:0]              dq6_mask,
   output logic [REQ_AW+$clog2(BANK_W/DEV_W)+$clog2(MAX_DEV_W)-1:0] cmd_addr,
   output logic [REQ_AW+$clog2(BANK_W/DEV_W)+$clog2(MAX_DEV_W)-1:0] query_addr,
   output logic [REQ_AW+$clog2(BANK_W/DEV_W)+$clog2(MAX_DEV_W)-1:0] data_addr
);

   localparam int LANES   = BANK_W / DEV_W;
   localparam int LW      = DEV_W * 8;
   localparam int CMD_SH  = $clog2(LANES) + $clog2(MAX_DEV_W);
   localparam int DATA_SH = $clog2(BANK_W);
   localparam int BUS_AW  = REQ_AW + CMD_SH;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign cmd_word[l*LW +: LW] = LW'(cmd_byte);
      assign dq6_mask[l*LW +: LW] = LW'(8'h40);
   end

   assign cmd_addr   = BUS_AW'(cmd_fa) << CMD_SH;
   assign query_addr = BUS_AW'(req_addr) << CMD_SH;
   assign data_addr  = BUS_AW'(req_addr) << DATA_SH;

endmodule

// File: rtl/flash_toggle_cmp.sv
module flash_toggle_cmp #(
   parameter int DW         = 32,
   parameter int POLL_LIMIT = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          sample,
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] mask,
   output logic          finished,
   output logic          expired
);

   localparam int CW = $clog2(POLL_LIMIT + 1);

   logic [DW-1:0] prev_q;
   logic          have_q;
   logic [CW-1:0] miss_q;
   logic          same;

   assign same     = ((rdata ^ prev_q) & mask) == '0;
   assign finished = sample & have_q & same;
   assign expired  = sample & have_q & ~same & (miss_q == CW'(POLL_LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         have_q <= 1'b0;
         miss_q <= '0;
      end else if (clr) begin
         have_q <= 1'b0;
         miss_q <= '0;
      end else if (sample) begin
         prev_q <= rdata;
         have_q <= 1'b1;
         if (have_q && !same) miss_q <= miss_q + 1'b1;
      end
   end

endmodule

// File: rtl/flash_ilv_seq.sv
module flash_ilv_seq
   import flash_seq_pkg::*;
#(
   parameter int BANK_W     = 4,
   parameter int DEV_W      = 1,
   parameter int MAX_DEV_W  = 2,
   parameter int REQ_AW     = 16,
   parameter int POLL_LIMIT = 1024
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [2:0]          req_op,
   input  logic [REQ_AW-1:0]   req_addr,
   input  logic [BANK_W*8-1:0] req_data,
   output logic                rsp_done,
   output logic                rsp_timeout,
   output logic [BANK_W*8-1:0] rsp_data,
   output logic [REQ_AW+$clog2(BANK_W/DEV_W)+$clog2(MAX_DEV_W)-1:0] bus_addr,
   output logic [BANK_W*8-1:0] bus_wdata,
   output logic                bus_we,
   output logic                bus_rd,
   input  logic [BANK_W*8-1:0] bus_rdata
);

   localparam int DW     = BANK_W * 8;
   localparam int CMD_SH = $clog2(BANK_W / DEV_W) + $clog2(MAX_DEV_W);
   localparam int BUS_AW = REQ_AW + CMD_SH;

   // elaboration-time configuration checks
   if ((BANK_W % DEV_W) != 0) begin : g_bad_ratio
      $error("BANK_W must be a multiple of DEV_W");
   end
   if (MAX_DEV_W < DEV_W) begin : g_bad_max
      $error("MAX_DEV_W must not be below DEV_W");
   end
   if ((BANK_W & (BANK_W - 1)) != 0 || (DEV_W & (DEV_W - 1)) != 0 ||
       (MAX_DEV_W & (MAX_DEV_W - 1)) != 0) begin : g_bad_pow2
      $error("widths must be powers of two");
   end
   if (REQ_AW < FA_W) begin : g_bad_aw
      $error("REQ_AW too narrow for command addresses");
   end
   if (POLL_LIMIT < 1) begin : g_bad_limit
      $error("POLL_LIMIT must be at least 1");
   end

   st_e                 state_q;
   logic [2:0]          op_q;
   logic [2:0]          idx_q;
   logic [REQ_AW-1:0]   addr_q;
   logic [DW-1:0]       data_q;
   logic [DW-1:0]       rd_q;
   logic                tmo_q;

   step_t               step;
   logic [7:0]          fan_byte;
   logic [DW-1:0]       cmd_word;
   logic [DW-1:0]       dq6_mask;
   logic [BUS_AW-1:0]   cmd_addr;
   logic [BUS_AW-1:0]   query_addr;
   logic [BUS_AW-1:0]   data_addr;
   logic                poll_clr;
   logic                poll_smp;
   logic                poll_fin;
   logic                poll_exp;

   flash_step_rom u_rom (
      .op   (op_q),
      .idx  (idx_q),
      .step (step)
   );

   assign fan_byte = (state_q == S_TORST) ? CB_RST : step.cb;

   flash_lane_fan #(
      .BANK_W    (BANK_W),
      .DEV_W     (DEV_W),
      .MAX_DEV_W (MAX_DEV_W),
      .REQ_AW    (REQ_AW)
   ) u_fan (
      .cmd_byte   (fan_byte),
      .cmd_fa     (step.fa),
      .req_addr   (addr_q),
      .cmd_word   (cmd_word),
      .dq6_mask   (dq6_mask),
      .cmd_addr   (cmd_addr),
      .query_addr (query_addr),
      .data_addr  (data_addr)
   );

   assign poll_clr = (state_q == S_STEP) && (step.kind == K_POLL);
   assign poll_smp = (state_q == S_POLL);

   flash_toggle_cmp #(
      .DW         (DW),
      .POLL_LIMIT (POLL_LIMIT)
   ) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (poll_clr),
      .sample   (poll_smp),
      .rdata    (bus_rdata),
      .mask     (dq6_mask),
      .finished (poll_fin),
      .expired  (poll_exp)
   );

   // bus drive
   always_comb begin
      bus_we    = 1'b0;
      bus_rd    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (state_q)
         S_STEP: begin
            case (step.kind)
               K_CMD: begin
                  bus_we    = 1'b1;
                  bus_addr  = cmd_addr;
                  bus_wdata = cmd_word;
               end
               K_DATA: begin
                  bus_we    = 1'b1;
                  bus_addr  = data_addr;
                  bus_wdata = data_q;
               end
               K_TGT: begin
                  bus_we    = 1'b1;
                  bus_addr  = data_addr;
                  bus_wdata = cmd_word;
               end
               K_READ: begin
                  bus_rd    = 1'b1;
                  bus_addr  = query_addr;
               end
               default: ;
            endcase
         end
         S_POLL: begin
            bus_rd   = 1'b1;
            bus_addr = (op_q == OP_CHIP) ? '0 : data_addr;
         end
         S_TORST: begin
            bus_we    = 1'b1;
            bus_addr  = '0;
            bus_wdata = cmd_word;
         end
         default: ;
      endcase
   end

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= '0;
         idx_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         rd_q    <= '0;
         tmo_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  op_q    <= req_op;
                  addr_q  <= req_addr;
                  data_q  <= req_data;
                  idx_q   <= '0;
                  tmo_q   <= 1'b0;
                  state_q <= S_STEP;
               end
            end
            S_STEP: begin
               case (step.kind)
                  K_POLL:  state_q <= S_POLL;
                  K_END:   state_q <= S_DONE;
                  K_READ: begin
                     rd_q  <= bus_rdata;
                     idx_q <= idx_q + 1'b1;
                  end
                  default: idx_q <= idx_q + 1'b1;
               endcase
            end
            S_POLL: begin
               if (poll_fin) begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= S_STEP;
               end else if (poll_exp) begin
                  state_q <= S_TORST;
               end
            end
            S_TORST: begin
               tmo_q   <= 1'b1;
               state_q <= S_DONE;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready   = (state_q == S_IDLE);
   assign rsp_done    = (state_q == S_DONE);
   assign rsp_timeout = tmo_q;
   assign rsp_data    = rd_q;

endmodule

// File: rtl/flash_ilv_seq_chk.sv
module flash_ilv_seq_chk #(
   parameter int AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          rsp_done,
   input logic          rsp_timeout,
   input logic          bus_we,
   input logic          bus_rd,
   input logic [AW-1:0] bus_addr
);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_we && !bus_rd && !rsp_done));

   assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_rd));

   assert_tmo_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_done && rsp_timeout) |-> ($past(bus_we) && $past(bus_addr) == '0));

   assert_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready));

endmodule

bind flash_ilv_seq flash_ilv_seq_chk #(.AW(BUS_AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .rsp_done    (rsp_done),
   .rsp_timeout (rsp_timeout),
   .bus_we      (bus_we),
   .bus_rd      (bus_rd),
   .bus_addr    (bus_addr)
);

// File: tb/test_flash_ilv_seq.sv
module test_flash_ilv_seq;

   localparam int BANK_W = 4;
   localparam int DEV_W  = 1;
   localparam int MAXW   = 2;
   localparam int REQ_AW = 16;
   localparam int LIMIT  = 8;
   localparam int DW     = BANK_W * 8;
   localparam int AW     = REQ_AW + 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_op = '0;
   logic [REQ_AW-1:0] req_addr = '0;
   logic [DW-1:0] req_data = '0;
   logic          rsp_done;
   logic          rsp_timeout;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_we;
   logic          bus_rd;
   logic [DW-1:0] bus_rdata;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;   // 50 MHz

   flash_ilv_seq #(
      .BANK_W(BANK_W), .DEV_W(DEV_W), .MAX_DEV_W(MAXW),
      .REQ_AW(REQ_AW), .POLL_LIMIT(LIMIT)
   ) i_flash_ilv_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
      .req_addr(req_addr), .req_data(req_data),
      .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_data(rsp_data),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
      .bus_rd(bus_rd), .bus_rdata(bus_rdata)
   );

   function automatic logic [DW-1:0] rep(input logic [7:0] b);
      logic [DW-1:0] r = '0;
      for (int i = 0; i < BANK_W / DEV_W; i++) r = r | (DW'(b) << (i * DEV_W * 8));
      return r;
   endfunction

   // ---------------- behavioural flash bank ----------------
   typedef enum logic [1:0] {M_ARR, M_QRY, M_IDN} mode_e;
   mode_e         mode;
   logic          armed, stat_on, tog, log_clr = 1'b0;
   int            busy_left, busy_k = 0;
   int            wn, nreads;
   logic [AW-1:0] wa [0:15];
   logic [DW-1:0] wd [0:15];
   logic [AW-1:0] raddr;

   always_comb begin
      bus_rdata = '0;
      case (mode)
         M_QRY: case (bus_addr >> 3)
                   'h10: bus_rdata = rep(8'h51);
                   'h11: bus_rdata = rep(8'h52);
                   'h12: bus_rdata = rep(8'h59);
                   default: bus_rdata = '0;
                endcase
         M_IDN: case (bus_addr >> 3)
                   'h0: bus_rdata = rep(8'hBF);
                   'h1: bus_rdata = rep(8'h6D);
                   default: bus_rdata = '0;
                endcase
         default: bus_rdata = stat_on ? (tog ? rep(8'h40) : '0) : '0;
      endcase
   end

   always @(posedge clk) begin
      if (!rst_n || log_clr) begin
         wn     <= 0;
         nreads <= 0;
         if (!rst_n) begin
            mode <= M_ARR; armed <= 1'b0; stat_on <= 1'b0; tog <= 1'b0;
            busy_left <= 0; raddr <= '0;
         end
      end else begin
         if (bus_we) begin
            if (wn < 16) begin
               wa[wn] <= bus_addr;
               wd[wn] <= bus_wdata;
               wn     <= wn + 1;
            end
            if (bus_wdata == rep(8'hF0)) begin
               mode <= M_ARR; stat_on <= 1'b0; armed <= 1'b0;
            end else if (armed || bus_wdata == rep(8'h30) || bus_wdata == rep(8'h10)) begin
               armed <= 1'b0; stat_on <= 1'b1; busy_left <= busy_k;
            end else if (bus_wdata == rep(8'h98)) mode <= M_QRY;
            else if (bus_wdata == rep(8'h90)) mode <= M_IDN;
            else if (bus_wdata == rep(8'hA0)) armed <= 1'b1;
         end
         if (bus_rd) begin
            nreads <= nreads + 1;
            raddr  <= bus_addr;
            if (busy_left > 0) begin
               busy_left <= busy_left - 1;
               tog       <= ~tog;
            end
         end
      end
   end

   // ---------------- checking helpers ----------------
   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   logic          got_tmo;
   logic [DW-1:0] got_data;

   task automatic run_op(input logic [2:0] op, input logic [REQ_AW-1:0] a,
                         input logic [DW-1:0] d, input bit hold);
      int cnt = 0;
      log_clr = 1'b1;
      @(negedge clk);
      log_clr = 1'b0;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
      @(negedge clk);
      chk("R12 ready drops after accept", req_ready, 0);
      if (!hold) req_valid = 1'b0;
      else req_op = 3'd5;
      while (!rsp_done && cnt < 300) begin
         @(negedge clk);
         cnt++;
      end
      req_valid = 1'b0;
      if (!rsp_done) begin
         n_chk++; n_err++;
         $display("FAIL R12 done never seen: got 0 expected 1");
      end
      got_tmo  = rsp_timeout;
      got_data = rsp_data;
      @(negedge clk);
      chk("R12 done lasts one cycle", rsp_done, 0);
      chk("R12 ready after done", req_ready, 1);
   endtask

   task automatic chk_w(input string tag, input int i, input logic [AW-1:0] a, input logic [DW-1:0] d);
      chk({tag, " addr"}, wa[i], a);
      chk({tag, " data"}, wd[i], d);
   endtask

   task automatic chk_unlock(input string tag, input int base);
      chk_w({tag, " unlock0"}, base, 19'h2AA8, rep(8'hAA));
      chk_w({tag, " unlock1"}, base + 1, 19'h1550, rep(8'h55));
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset_state;
      chk("R1 ready after reset", req_ready, 1);
      chk("R1 done after reset", rsp_done, 0);
      chk("R1 no strobes after reset", {bus_we, bus_rd}, 0);
   endtask

   task automatic t_reset_op;
      run_op(3'd0, 16'h0, '0, 0);
      chk("R4 write count", wn, 1);
      chk_w("R4 R3 reset word", 0, '0, 32'hF0F0F0F0);
      chk("R4 no reads", nreads, 0);
   endtask

   task automatic t_program;
      busy_k = 3;
      run_op(3'd3, 16'h0123, 32'hCAFE1234, 0);
      chk("R5 write count", wn, 4);
      chk_unlock("R5 R2 R3", 0);
      chk_w("R5 setup", 2, 19'h2AA8, 32'hA0A0A0A0);
      chk_w("R5 R2 data", 3, 19'h048C, 32'hCAFE1234);
      chk("R8 poll reads", nreads, 5);
      chk("R8 poll address", raddr, 19'h048C);
      chk("R8 no timeout", got_tmo, 0);
   endtask

   task automatic t_poll_bounds;
      busy_k = LIMIT - 1;
      run_op(3'd3, 16'h0010, 32'h00000001, 0);
      chk("R9 under limit no timeout", got_tmo, 0);
      chk("R9 under limit writes", wn, 4);
      chk("R8 under limit reads", nreads, LIMIT + 1);
      busy_k = LIMIT;
      run_op(3'd3, 16'h0010, 32'h00000001, 0);
      chk("R9 at limit timeout", got_tmo, 1);
      chk("R9 at limit writes", wn, 5);
      chk_w("R9 recovery reset", 4, '0, rep(8'hF0));
      chk("R9 at limit reads", nreads, LIMIT + 1);
   endtask

   task automatic t_sector;
      busy_k = 2;
      run_op(3'd4, 16'h0800, '0, 0);
      chk("R6 write count", wn, 6);
      chk_unlock("R6 first", 0);
      chk_w("R6 erase setup", 2, 19'h2AA8, rep(8'h80));
      chk_unlock("R6 second", 3);
      chk_w("R6 sector target", 5, 19'h2000, 32'h30303030);
      chk("R6 poll address", raddr, 19'h2000);
   endtask

   task automatic t_chip;
      busy_k = 4;
      run_op(3'd5, 16'h0444, '0, 0);
      chk("R7 write count", wn, 6);
      chk_w("R7 erase setup", 2, 19'h2AA8, rep(8'h80));
      chk_w("R7 chip command", 5, 19'h2AA8, 32'h10101010);
      chk("R7 poll address zero", raddr, 0);
      chk("R7 R8 poll reads", nreads, 6);
   endtask

   task automatic t_query;
      run_op(3'd2, 16'h0010, '0, 0);
      chk("R10 write count", wn, 2);
      chk_w("R10 enter", 0, 19'h02A8, 32'h98989898);
      chk_w("R10 exit", 1, '0, rep(8'hF0));
      chk("R10 read address", raddr, 19'h0080);
      chk("R10 data Q", got_data, 32'h51515151);
      run_op(3'd2, 16'h0012, '0, 0);
      chk("R10 data Y", got_data, 32'h59595959);
   endtask

   task automatic t_ident;
      run_op(3'd1, 16'h0000, '0, 0);
      chk("R11 write count", wn, 4);
      chk_unlock("R11", 0);
      chk_w("R11 enter", 2, 19'h2AA8, 32'h90909090);
      chk_w("R11 exit", 3, '0, rep(8'hF0));
      chk("R11 data", got_data, 32'hBFBFBFBF);
      run_op(3'd1, 16'h0001, '0, 0);
      chk("R11 second word", got_data, 32'h6D6D6D6D);
   endtask

   task automatic t_hold_busy;
      busy_k = 5;
      run_op(3'd3, 16'h0020, 32'h5A5A5A5A, 1);
      repeat (3) @(negedge clk);
      chk("R12 held request ignored writes", wn, 4);
      chk("R12 still idle", req_ready, 1);
   endtask

   task automatic t_unknown;
      run_op(3'd7, 16'h0100, '0, 0);
      chk("R13 no writes", wn, 0);
      chk("R13 no reads", nreads, 0);
      run_op(3'd6, 16'h0100, '0, 0);
      chk("R13 code 6 no writes", wn, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_reset_op();
      t_program();
      t_poll_bounds();
      t_sector();
      t_chip();
      t_query();
      t_ident();
      t_hold_busy();
      t_unknown();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule